// File: doc/BRIEF.md
# Scaled Float-to-Integer Converter

This block turns a single-precision IEEE-754 operand into a 32-bit integer, either two's-complement signed or unsigned. Before rounding, the operand is multiplied by two raised to a small unsigned immediate. The multiply only adjusts the exponent, so it is exact and never rounds. The caller supplies the rounding direction with each operation, so the control register's mode is bypassed. The flags come back alongside the result so that the surrounding unit can merge them into its sticky status.

The datapath is combinational from the input to one output register. A result therefore appears one clock after its valid strobe. A conversion to unsigned of a negative, non-NaN value follows the signed rules. Such a result raises the invalid flag only when the integer it produces is not zero.

Top module: `fti_convert`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low in the cycle after a cycle with `in_valid` low. `out_int` and `out_flags` belong to the operation accepted one clock earlier.
- R2: While `rst` is high at a clock edge, `out_valid`, `out_int` and `out_flags` are cleared to zero.
- R3: The operand's value is multiplied exactly by 2^`in_scale`, where `in_scale` is unsigned, before it is rounded to an integer. Subnormal operands take part with their true value.
- R4: `in_round` selects the rounding direction: 0 rounds to nearest with ties to even, 1 rounds toward zero, 2 rounds toward +infinity and 3 rounds toward -infinity.
- R5: When an in-range result differs from the scaled value, the inexact flag is raised.
- R6: In signed mode, a rounded value above 2^31-1 returns 0x7FFFFFFF and a rounded value below -2^31 returns 0x80000000. In both cases the flags are the invalid flag alone.
- R7: In unsigned mode with a positive operand, a rounded value above 2^32-1 returns 0xFFFFFFFF with the invalid flag alone.
- R8: A NaN of either sign returns 0x7FFFFFFF in signed mode and 0xFFFFFFFF in unsigned mode, with the invalid flag alone. In unsigned mode the sign of the NaN is ignored.
- R9: In unsigned mode, a negative non-NaN operand is converted by the signed rules. If the resulting integer is non-zero, the flags are the invalid flag alone. If it is zero, the flags are those of the signed conversion.
- R10: `out_flags` bit 0 is inexact, bit 1 underflow, bit 2 overflow, bit 3 divide-by-zero and bit 4 invalid. Bits 1 to 3 are never raised, because the scaled conversion cannot set them.
- R11: Infinities count as out of range. In signed mode, +inf gives 0x7FFFFFFF and -inf gives 0x80000000. In unsigned mode, +inf gives 0xFFFFFFFF and -inf gives 0x80000000 by the rule of R9. Each case raises invalid.
- R12: In a cycle after `in_valid` was low, `out_int` and `out_flags` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| in_value | input | 32 | Single-precision operand |
| in_scale | input | SCALE_W | Unsigned power-of-two scale |
| in_round | input | 2 | Rounding direction for this operation |
| in_unsigned | input | 1 | 1 selects unsigned result, 0 signed |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_int | output | 32 | Integer result |
| out_flags | output | 5 | Exception flags (see R10) |

## Verification
The bench targets exact ties under round-to-nearest. A design that rounds ties away from zero would return 3 for 2.5, where 2 is expected. It also drives the limits -2^31, 2^31 and 2^32 in both modes. There, an off-by-one range test would saturate a legal -2^31, or pass 2^31 through in signed mode. Small negative values go to unsigned mode under each rounding direction. A design that always raised invalid for them, or kept inexact next to invalid, would show wrong flags. NaNs with the sign bit set go to unsigned mode, where taking the negative path would return 0x80000000 instead of all ones.

// File: rtl/fti_pkg.sv
package fti_pkg;

    localparam int FP_W     = 32;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int SIG_W    = MAN_W + 1;
    localparam int EXP_BIAS = 127;
    localparam int INT_W    = 32;
    localparam int FLAG_W   = 5;
    localparam int SHIFT_W  = 16;

    // flag bit positions
    localparam int FLG_INEXACT = 0;
    localparam int FLG_UNDER   = 1;
    localparam int FLG_OVER    = 2;
    localparam int FLG_DIVZ    = 3;
    localparam int FLG_INVALID = 4;

    typedef logic signed [SHIFT_W-1:0] shift_t;

    typedef enum logic [1:0] {
        RND_NEAREST = 2'd0,
        RND_ZERO    = 2'd1,
        RND_UP      = 2'd2,
        RND_DOWN    = 2'd3
    } rnd_mode_e;

    typedef enum logic [1:0] {
        CLS_FINITE = 2'd0,
        CLS_INF    = 2'd1,
        CLS_NAN    = 2'd2
    } cls_e;

    // decoded operand: value = sig * 2^shift
    typedef struct packed {
        logic             sign;
        cls_e             cls;
        logic [SIG_W-1:0] sig;
        shift_t           shift;
    } unpacked_t;

    // integer part plus the rounding bits
    typedef struct packed {
        logic             sign;
        cls_e             cls;
        logic             huge;
        logic [INT_W:0]   whole;
        logic             guard;
        logic             sticky;
    } aligned_t;

    typedef struct packed {
        logic             sign;
        cls_e             cls;
        logic             huge;
        logic [INT_W+1:0] mag;
        logic             lost;
    } rounded_t;

    typedef struct packed {
        logic [INT_W-1:0]  value;
        logic [FLAG_W-1:0] flags;
    } conv_res_t;

    function automatic logic [FLAG_W-1:0] flag_only(input int pos);
        logic [FLAG_W-1:0] f;
        f = '0;
        f[pos] = 1'b1;
        return f;
    endfunction

    // whether the magnitude must be incremented
    function automatic logic need_increment(input rnd_mode_e m, input logic sign,
                                            input logic lsb, input logic g, input logic s);
        logic inc;
        case (m)
            RND_NEAREST: inc = g & (s | lsb);
            RND_ZERO:    inc = 1'b0;
            RND_UP:      inc = ~sign & (g | s);
            default:     inc = sign & (g | s);
        endcase
        return inc;
    endfunction

endpackage

// File: rtl/fti_unpack.sv
module fti_unpack
    import fti_pkg::*;
#(
    parameter int SCALE_W = 4
) (
    input  logic [FP_W-1:0]    value,
    input  logic [SCALE_W-1:0] scale,
    output unpacked_t          up
);

    localparam int FRAC_BIAS = EXP_BIAS + MAN_W;

    logic [EXP_W-1:0] raw_exp;
    logic [MAN_W-1:0] raw_frac;
    logic [EXP_W-1:0] eff_exp;
    logic             exp_max;
    logic             exp_zero;

    always_comb begin
        raw_exp  = value[FP_W-2 -: EXP_W];
        raw_frac = value[MAN_W-1:0];
        exp_max  = &raw_exp;
        exp_zero = ~|raw_exp;
        eff_exp  = exp_zero ? EXP_W'(1) : raw_exp;

        up.sign = value[FP_W-1];
        if (exp_max)
            up.cls = (|raw_frac) ? CLS_NAN : CLS_INF;
        else
            up.cls = CLS_FINITE;
        up.sig   = {~exp_zero, raw_frac};
        up.shift = shift_t'({{(SHIFT_W-EXP_W){1'b0}}, eff_exp})
                 - shift_t'(FRAC_BIAS)
                 + shift_t'({{(SHIFT_W-SCALE_W){1'b0}}, scale});
    end

endmodule

// File: rtl/fti_align.sv
module fti_align
    import fti_pkg::*;
(
    input  unpacked_t up,
    output aligned_t  al
);

    localparam int WIDE_W   = SIG_W + INT_W + 2;
    localparam int EXT_W    = 2 * SIG_W + 1;
    localparam int LEFT_MAX = INT_W + 2;
    localparam int RIGHT_MAX = SIG_W + 2;

    logic [WIDE_W-1:0]  wide;
    logic [EXT_W-1:0]   ext;
    logic [SHIFT_W-1:0] rsh;
    logic               left;

    always_comb begin
        al        = '0;
        al.sign   = up.sign;
        al.cls    = up.cls;
        wide      = '0;
        ext       = '0;
        rsh       = '0;
        left      = ($signed(up.shift) >= 0);
        if (left) begin
            if ($signed(up.shift) >= $signed(shift_t'(LEFT_MAX))) begin
                al.huge = |up.sig;
            end else begin
                wide     = {{(WIDE_W-SIG_W){1'b0}}, up.sig} << up.shift;
                al.huge  = |wide[WIDE_W-1:INT_W+1];
                al.whole = wide[INT_W:0];
            end
        end else begin
            rsh = SHIFT_W'(-up.shift);
            if (rsh >= SHIFT_W'(RIGHT_MAX)) begin
                al.sticky = |up.sig;
            end else begin
                ext       = {up.sig, {(SIG_W+1){1'b0}}} >> rsh;
                al.whole  = {{(INT_W+1-SIG_W){1'b0}}, ext[EXT_W-1:SIG_W+1]};
                al.guard  = ext[SIG_W];
                al.sticky = |ext[SIG_W-1:0];
            end
        end
    end

endmodule

// File: rtl/fti_round.sv
module fti_round
    import fti_pkg::*;
(
    input  aligned_t  al,
    input  rnd_mode_e mode,
    output rounded_t  rd
);

    logic inc;

    always_comb begin
        inc     = need_increment(mode, al.sign, al.whole[0], al.guard, al.sticky);
        rd.sign = al.sign;
        rd.cls  = al.cls;
        rd.huge = al.huge;
        rd.mag  = {1'b0, al.whole} + (INT_W+2)'(inc);
        rd.lost = al.guard | al.sticky;
    end

endmodule

// File: rtl/fti_range.sv
module fti_range
    import fti_pkg::*;
(
    input  rounded_t  rd,
    input  logic      to_unsigned,
    output conv_res_t res
);

    localparam logic [INT_W+1:0] POS_S_LIM = ((INT_W+2)'(1) << (INT_W-1)) - (INT_W+2)'(1);
    localparam logic [INT_W+1:0] NEG_S_LIM = (INT_W+2)'(1) << (INT_W-1);
    localparam logic [INT_W+1:0] U_LIM     = ((INT_W+2)'(1) << INT_W) - (INT_W+2)'(1);
    localparam logic [INT_W-1:0] S_MAX     = {1'b0, {(INT_W-1){1'b1}}};
    localparam logic [INT_W-1:0] S_MIN     = {1'b1, {(INT_W-1){1'b0}}};
    localparam logic [INT_W-1:0] U_MAX     = {INT_W{1'b1}};

    logic              too_big;
    logic              use_signed;
    logic [INT_W-1:0]  low_mag;
    logic [FLAG_W-1:0] exact_flags;

    always_comb begin
        low_mag     = rd.mag[INT_W-1:0];
        exact_flags = rd.lost ? flag_only(FLG_INEXACT) : '0;
        use_signed  = ~to_unsigned | rd.sign;
        too_big     = 1'b0;
        res         = '0;

        if (rd.cls == CLS_NAN) begin
            res.value = to_unsigned ? U_MAX : S_MAX;
            res.flags = flag_only(FLG_INVALID);
        end else if (use_signed) begin
            too_big = (rd.cls == CLS_INF) | rd.huge
                    | (rd.sign ? (rd.mag > NEG_S_LIM) : (rd.mag > POS_S_LIM));
            if (too_big) begin
                res.value = rd.sign ? S_MIN : S_MAX;
                res.flags = flag_only(FLG_INVALID);
            end else begin
                res.value = rd.sign ? (~low_mag + INT_W'(1)) : low_mag;
                res.flags = exact_flags;
            end
            // negative operand on the unsigned path
            if (to_unsigned && (res.value != '0))
                res.flags = flag_only(FLG_INVALID);
        end else begin
            too_big = (rd.cls == CLS_INF) | rd.huge | (rd.mag > U_LIM);
            if (too_big) begin
                res.value = U_MAX;
                res.flags = flag_only(FLG_INVALID);
            end else begin
                res.value = low_mag;
                res.flags = exact_flags;
            end
        end
    end

endmodule

// File: rtl/fti_convert.sv
module fti_convert
    import fti_pkg::*;
#(
    parameter int SCALE_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [FP_W-1:0]    in_value,
    input  logic [SCALE_W-1:0] in_scale,
    input  logic [1:0]         in_round,
    input  logic               in_unsigned,
    output logic               out_valid,
    output logic [INT_W-1:0]   out_int,
    output logic [FLAG_W-1:0]  out_flags
);

    unpacked_t up;
    aligned_t  al;
    rounded_t  rd;
    conv_res_t cv;
    rnd_mode_e mode;

    logic              valid_q;
    logic [INT_W-1:0]  int_q;
    logic [FLAG_W-1:0] flags_q;

    assign mode = rnd_mode_e'(in_round);

    fti_unpack #(.SCALE_W(SCALE_W)) u_unpack (
        .value (in_value),
        .scale (in_scale),
        .up    (up)
    );

    fti_align u_align (
        .up (up),
        .al (al)
    );

    fti_round u_round (
        .al   (al),
        .mode (mode),
        .rd   (rd)
    );

    fti_range u_range (
        .rd          (rd),
        .to_unsigned (in_unsigned),
        .res         (cv)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            int_q   <= '0;
            flags_q <= '0;
        end else begin
            valid_q <= in_valid;
            if (in_valid) begin
                int_q   <= cv.value;
                flags_q <= cv.flags;
            end
        end
    end

    assign out_valid = valid_q;
    assign out_int   = int_q;
    assign out_flags = flags_q;

    AST_VALID_RISE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(out_int) && $stable(out_flags))); // R12
    AST_NAN_SIGNED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && up.cls == CLS_NAN && !in_unsigned) |=> (out_int == {1'b0, {(INT_W-1){1'b1}}})); // R8
    AST_NEG_UNS_INVALID: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_unsigned && up.sign && up.cls != CLS_NAN)
        |=> ((out_int != '0) == out_flags[FLG_INVALID])); // R9
    AST_INVALID_ALONE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_flags[FLG_INVALID]) |-> !out_flags[FLG_INEXACT]); // R6

endmodule

// File: tb/fti_convert_test.sv
module fti_convert_test;

    localparam int CLK_PERIOD = 10;
    localparam int SCALE_W    = 4;
    localparam int N_RANDOM   = 4000;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic [31:0]        in_value = '0;
    logic [SCALE_W-1:0] in_scale = '0;
    logic [1:0]         in_round = '0;
    logic               in_unsigned = 1'b0;
    logic               out_valid;
    logic [31:0]        out_int;
    logic [4:0]         out_flags;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fti_convert #(.SCALE_W(SCALE_W)) uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_value   (in_value),
        .in_scale   (in_scale),
        .in_round   (in_round),
        .in_unsigned(in_unsigned),
        .out_valid  (out_valid),
        .out_int    (out_int),
        .out_flags  (out_flags)
    );

    localparam logic [4:0] F_NONE = 5'b00000;
    localparam logic [4:0] F_INX  = 5'b00001;
    localparam logic [4:0] F_INV  = 5'b10000;

    function automatic real round_real(input real v, input logic [1:0] rm);
        real fl;
        real d;
        fl = $floor(v);
        d  = v - fl;
        case (rm)
            2'd0: begin
                if (d > 0.5) return fl + 1.0;
                if (d < 0.5) return fl;
                if ($floor(fl / 2.0) * 2.0 == fl) return fl;
                return fl + 1.0;
            end
            2'd1: return (v >= 0.0) ? fl : $ceil(v);
            2'd2: return $ceil(v);
            default: return fl;
        endcase
    endfunction

    task automatic model(input logic [31:0] op, input int scale, input logic [1:0] rm,
                         input logic uns, output logic [31:0] res, output logic [4:0] fl);
        int   e;
        int   f;
        real  a;
        real  v;
        real  r;
        logic s;
        s = op[31];
        e = int'(op[30:23]);
        f = int'(op[22:0]);
        if (e == 255 && f != 0) begin
            res = uns ? 32'hFFFF_FFFF : 32'h7FFF_FFFF;
            fl  = F_INV;
            return;
        end
        if (e == 255) a = 1.0e300;
        else if (e == 0) a = real'(f) * (2.0 ** (1 - 150 + scale));
        else a = real'(f + 8388608) * (2.0 ** (e - 150 + scale));
        v = s ? -a : a;
        r = round_real(v, rm);
        if (!uns || s) begin
            if (r > 2147483647.0) begin
                res = 32'h7FFF_FFFF; fl = F_INV;
            end else if (r < -2147483648.0) begin
                res = 32'h8000_0000; fl = F_INV;
            end else begin
                res = 32'(longint'(r));
                fl  = (r != v) ? F_INX : F_NONE;
            end
            if (uns && res != 32'd0) fl = F_INV;
        end else begin
            if (r > 4294967295.0) begin
                res = 32'hFFFF_FFFF; fl = F_INV;
            end else begin
                res = 32'(longint'(r));
                fl  = (r != v) ? F_INX : F_NONE;
            end
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // drive at a falling edge, check at the next falling edge
    task automatic run_op(input logic [31:0] op, input int sc, input logic [1:0] rm,
                          input logic uns, input logic [31:0] exp_res,
                          input logic [4:0] exp_fl, input string tag);
        in_valid    = 1'b1;
        in_value    = op;
        in_scale    = SCALE_W'(sc);
        in_round    = rm;
        in_unsigned = uns;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R1 valid"}, {31'd0, out_valid}, 32'd1);
        check({tag, " result"}, out_int, exp_res);
        check({tag, " flags"}, {27'd0, out_flags}, {27'd0, exp_fl});
    endtask

    function automatic logic [31:0] rand_operand();
        logic [31:0] x;
        int cls;
        cls = int'($urandom % 8);
        x = $urandom;
        case (cls)
            5: ;
            6: case ($urandom % 4)
                   0: x[30:0] = 31'h7F80_0000;
                   1: x[30:0] = 31'h7FC0_0000 | (x[30:0] & 31'h003F_FFFF);
                   2: x[30:0] = 31'd0;
                   default: x[30:23] = 8'd0;
               endcase
            7: x[30:23] = 8'(156 + ($urandom % 4));
            default: x[30:23] = 8'(112 + ($urandom % 50));
        endcase
        return x;
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] er;
        logic [4:0]  ef;
        logic [31:0] held_int;
        logic [4:0]  held_fl;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R2: reset state
        check("R2 valid", {31'd0, out_valid}, 32'd0);
        check("R2 result", out_int, 32'd0);
        check("R2 flags", {27'd0, out_flags}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle valid", {31'd0, out_valid}, 32'd0);

        // R3 scaling
        run_op(32'h3F80_0000, 5, 2'd1, 1'b0, 32'd32, F_NONE, "R3 1.0*2^5");
        run_op(32'h3FC0_0000, 1, 2'd0, 1'b0, 32'd3, F_NONE, "R3 1.5*2^1");
        run_op(32'h3E80_0000, 2, 2'd1, 1'b1, 32'd1, F_NONE, "R3 0.25*2^2");
        run_op(32'h0000_0001, 15, 2'd2, 1'b0, 32'd1, F_INX, "R3 subnormal up");
        // R4 modes on +-2.5 and 3.5
        run_op(32'h4020_0000, 0, 2'd0, 1'b0, 32'd2, F_INX, "R4 2.5 nearest");
        run_op(32'h4060_0000, 0, 2'd0, 1'b0, 32'd4, F_INX, "R4 3.5 nearest");
        run_op(32'h4020_0000, 0, 2'd1, 1'b0, 32'd2, F_INX, "R4 2.5 zero");
        run_op(32'h4020_0000, 0, 2'd2, 1'b0, 32'd3, F_INX, "R4 2.5 up");
        run_op(32'h4020_0000, 0, 2'd3, 1'b0, 32'd2, F_INX, "R4 2.5 down");
        run_op(32'hC020_0000, 0, 2'd0, 1'b0, 32'hFFFF_FFFE, F_INX, "R4 -2.5 nearest");
        run_op(32'hC020_0000, 0, 2'd2, 1'b0, 32'hFFFF_FFFE, F_INX, "R4 -2.5 up");
        run_op(32'hC020_0000, 0, 2'd3, 1'b0, 32'hFFFF_FFFD, F_INX, "R4 -2.5 down");
        // R5
        run_op(32'h3E80_0000, 0, 2'd1, 1'b0, 32'd0, F_INX, "R5 0.25 to zero");
        // R6 signed limits
        run_op(32'h4F00_0000, 0, 2'd0, 1'b0, 32'h7FFF_FFFF, F_INV, "R6 2^31 signed");
        run_op(32'hCF00_0000, 0, 2'd0, 1'b0, 32'h8000_0000, F_NONE, "R6 -2^31 signed");
        run_op(32'h4E80_0000, 1, 2'd0, 1'b0, 32'h7FFF_FFFF, F_INV, "R6 2^30*2");
        run_op(32'hCF00_0001, 0, 2'd1, 1'b0, 32'h8000_0000, F_INV, "R6 below -2^31");
        // R7 unsigned limits
        run_op(32'h4F80_0000, 0, 2'd0, 1'b1, 32'hFFFF_FFFF, F_INV, "R7 2^32 unsigned");
        run_op(32'h4F00_0000, 0, 2'd0, 1'b1, 32'h8000_0000, F_NONE, "R7 2^31 unsigned");
        // R8 NaN
        run_op(32'h7FC0_0000, 0, 2'd0, 1'b0, 32'h7FFF_FFFF, F_INV, "R8 NaN signed");
        run_op(32'h7FC0_0000, 0, 2'd0, 1'b1, 32'hFFFF_FFFF, F_INV, "R8 NaN unsigned");
        run_op(32'hFFC0_0001, 3, 2'd3, 1'b1, 32'hFFFF_FFFF, F_INV, "R8 negative NaN unsigned");
        // R9 negative unsigned
        run_op(32'hBF80_0000, 0, 2'd0, 1'b1, 32'hFFFF_FFFF, F_INV, "R9 -1.0 unsigned");
        run_op(32'hBE80_0000, 0, 2'd1, 1'b1, 32'd0, F_INX, "R9 -0.25 to zero");
        run_op(32'hBE80_0000, 0, 2'd3, 1'b1, 32'hFFFF_FFFF, F_INV, "R9 -0.25 down");
        run_op(32'h8000_0000, 0, 2'd0, 1'b1, 32'd0, F_NONE, "R9 -0.0");
        // R11 infinities
        run_op(32'h7F80_0000, 0, 2'd0, 1'b0, 32'h7FFF_FFFF, F_INV, "R11 +inf signed");
        run_op(32'hFF80_0000, 0, 2'd0, 1'b0, 32'h8000_0000, F_INV, "R11 -inf signed");
        run_op(32'h7F80_0000, 0, 2'd0, 1'b1, 32'hFFFF_FFFF, F_INV, "R11 +inf unsigned");
        run_op(32'hFF80_0000, 0, 2'd0, 1'b1, 32'h8000_0000, F_INV, "R11 -inf unsigned");

        // R12 hold while idle
        run_op(32'h4120_0000, 0, 2'd0, 1'b0, 32'd10, F_NONE, "R12 setup");
        held_int = out_int;
        held_fl  = out_flags;
        in_value = 32'h4F80_0000;
        in_unsigned = 1'b1;
        repeat (2) @(negedge clk);
        check("R12 idle valid", {31'd0, out_valid}, 32'd0);
        check("R12 held result", out_int, held_int);
        check("R12 held flags", {27'd0, out_flags}, {27'd0, held_fl});

        // random sweep against the bench model (R3 R4 R5 R10)
        for (int i = 0; i < N_RANDOM; i++) begin
            logic [31:0] op;
            int          sc;
            logic [1:0]  rm;
            logic        un;
            op = rand_operand();
            sc = int'($urandom % (1 << SCALE_W));
            rm = 2'($urandom);
            un = 1'($urandom);
            model(op, sc, rm, un, er, ef);
            run_op(op, sc, rm, un, er, ef, "R4 random");
            check("R10 spare flags", {29'd0, out_flags[3:1]}, 32'd0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule